// File: doc/BRIEF.md
# Scheduled Backup Cell Test Controller

This block decides when a backup cell is put under a test load and keeps an active-low warning flag that reports a weak cell. All timing is counted in ticks of a prescaled time base, which is normally one tick per second. A test connects the load for `PULSE_TICKS` ticks. The comparator result is taken only on the last cycle of that window. If the loaded voltage reads low at that moment, the warning is raised.

While the warning is clear, tests are spaced `NORM_TICKS` ticks apart. While it is set, they are spaced `WARN_TICKS` ticks apart, so that a cell swap is noticed quickly. The warning is sticky. It is released only when two things have happened in this order. First, the cell has been absent for at least `MIN_DETACH_TICKS` consecutive ticks and has then been refitted. Second, a later test has passed. Between tests the cell is not watched.

Testing stops whenever the supply is reported failed. After each power-up, once the recovery time has elapsed, a test runs straight away, whatever the warning state.

The controller has three states:
- **OFF**: no testing.
- **WAIT**: counting the gap to the next test.
- **TEST**: load enabled.

Its transitions are:
- **power-up**: OFF to TEST, when the supply is valid and recovery is done.
- **gap-expired**: WAIT to TEST.
- **window-end**: TEST to WAIT. The warning is updated on this transition.
- **supply-lost**: WAIT or TEST to OFF.

Top module: `batt_test_ctrl`

## Requirements
- R1: During and right after reset, `load_en` is 0 and `warn_n` is 1 (released).
- R2: A test window keeps `load_en` at 1 for exactly `PULSE_TICKS` ticks.
- R3: No test runs while `recovery_done` is 0. In the cycle after `supply_ok` and `recovery_done` are first both 1, `load_en` is 1.
- R4: With the warning clear, the next test starts exactly `NORM_TICKS` ticks after the previous window ends.
- R5: If `cmp_ok` is 0 on the last cycle of a window, `warn_n` is 0 from the next cycle.
- R6: `cmp_ok` is ignored on every cycle of a window except the last. A low reading earlier in the window, followed by a high reading at the end, leaves `warn_n` at 1.
- R7: With the warning set, the next test starts exactly `WARN_TICKS` ticks after the previous window ends.
- R8: A passing test does not release the warning unless a qualifying detach happened before it.
- R9: After the cell has been absent for at least `MIN_DETACH_TICKS` consecutive ticks and then refitted, the next passing test sets `warn_n` to 1. The gap after that test is `NORM_TICKS`.
- R10: An absence shorter than `MIN_DETACH_TICKS` ticks does not qualify. Refitting the cell restarts the absence count from zero.
- R11: When `supply_ok` falls, `load_en` is 0 from the next cycle. An aborted window does not change the warning. No test runs while the supply is failed.
- R12: The warning persists through a supply failure. A test still runs at the next power-up even while the warning is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse from the time-base prescaler |
| supply_ok | input | 1 | Main supply within tolerance |
| recovery_done | input | 1 | Post-power-up recovery time has elapsed |
| cell_present | input | 1 | Backup cell is attached |
| cmp_ok | input | 1 | 1 when the loaded cell voltage is above threshold |
| load_en | output | 1 | Connects the test load to the cell |
| warn_n | output | 1 | Warning, active low (0 = pull low, 1 = release) |

## Verification
A wrong state or counter in this block shows up at the ports as a test window or a gap of the wrong length. It is visible on the first `load_en` edge after the fault, which is at most one full period away. A corrupted warning or replacement record shows up as a `warn_n` change that fails to happen, or happens early, at the end of the next window; with the warning set, that is within `WARN_TICKS` plus `PULSE_TICKS` ticks. Supply-loss faults appear one cycle after `supply_ok` falls, as `load_en` staying high.

// File: rtl/btc_pkg.sv
package btc_pkg;
    typedef enum logic [1:0] {
        BTC_OFF  = 2'd0,
        BTC_WAIT = 2'd1,
        BTC_TEST = 2'd2
    } btc_state_e;
endpackage

// File: rtl/btc_interval_ctr.sv
// Tick counter with a runtime limit; done marks the tick that completes the limit.
module btc_interval_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_m1;

    assign lim_m1 = limit - W'(1);
    assign done   = tick && !clr && (cnt_q == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == lim_m1) cnt_q <= '0;
            else                 cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/btc_detach_timer.sv
// Records a refit that follows an absence of at least MIN_TICKS ticks.
module btc_detach_timer #(
    parameter int MIN_TICKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic present,
    input  logic consume,
    output logic refitted
);
    localparam int W = $clog2(MIN_TICKS + 1);

    logic [W-1:0] gone_q;
    logic         refit_q;

    assign refitted = refit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gone_q  <= '0;
            refit_q <= 1'b0;
        end else begin
            if (!present) begin
                if (tick && gone_q != W'(MIN_TICKS)) gone_q <= gone_q + W'(1);
            end else begin
                gone_q <= '0;
            end

            if (present && gone_q == W'(MIN_TICKS)) refit_q <= 1'b1;
            else if (consume)                       refit_q <= 1'b0;
        end
    end
endmodule

// File: rtl/batt_test_ctrl.sv
module batt_test_ctrl #(
    parameter int NORM_TICKS       = 86400,
    parameter int WARN_TICKS       = 5,
    parameter int PULSE_TICKS      = 1,
    parameter int MIN_DETACH_TICKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic recovery_done,
    input  logic cell_present,
    input  logic cmp_ok,
    output logic load_en,
    output logic warn_n
);
    import btc_pkg::*;

    localparam int MAX_A = (NORM_TICKS > WARN_TICKS) ? NORM_TICKS : WARN_TICKS;
    localparam int MAX_P = (MAX_A > PULSE_TICKS) ? MAX_A : PULSE_TICKS;
    localparam int CW    = $clog2(MAX_P + 1);

    btc_state_e state_q, state_d;
    logic       warn_q;
    logic       ctr_done;
    logic       ctr_clr;
    logic       test_end;
    logic       refitted;
    logic [CW-1:0] limit;

    assign ctr_clr  = (state_q == BTC_OFF) || !supply_ok;
    assign test_end = (state_q == BTC_TEST) && supply_ok && ctr_done;

    always_comb begin
        if (state_q == BTC_TEST) limit = CW'(PULSE_TICKS);
        else if (warn_q)         limit = CW'(WARN_TICKS);
        else                     limit = CW'(NORM_TICKS);
    end

    btc_interval_ctr #(.W(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .tick  (tick),
        .limit (limit),
        .done  (ctr_done)
    );

    btc_detach_timer #(.MIN_TICKS(MIN_DETACH_TICKS)) u_detach (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .present  (cell_present),
        .consume  (test_end),
        .refitted (refitted)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BTC_OFF:  if (supply_ok && recovery_done) state_d = BTC_TEST;
            BTC_WAIT: begin
                if (!supply_ok)    state_d = BTC_OFF;
                else if (ctr_done) state_d = BTC_TEST;
            end
            BTC_TEST: begin
                if (!supply_ok)    state_d = BTC_OFF;
                else if (ctr_done) state_d = BTC_WAIT;
            end
            default:               state_d = BTC_OFF;
        endcase
    end

    // State and warning registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BTC_OFF;
            warn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (test_end) begin
                if (!cmp_ok)       warn_q <= 1'b1;
                else if (refitted) warn_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        load_en = (state_q == BTC_TEST);
        warn_n  = !warn_q;
    end
endmodule

// File: rtl/batt_test_ctrl_chk.sv
module batt_test_ctrl_chk #(
    parameter int PULSE_TICKS = 1
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic supply_ok,
    input logic cmp_ok,
    input logic load_en,
    input logic warn_n
);
    localparam int WW = $clog2(PULSE_TICKS + 1);
    logic [WW-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              win_q <= '0;
        else if (!load_en)       win_q <= '0;
        else if (tick)           win_q <= win_q + WW'(1);
    end

    p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (win_q < WW'(PULSE_TICKS)));

    p_warn_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && supply_ok && tick && win_q == WW'(PULSE_TICKS - 1) && !cmp_ok) |=> !warn_n);

    p_warn_fall_only_in_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn_n) |-> ($past(load_en) && $past(tick) && !$past(cmp_ok)));

    p_release_on_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_n) |-> ($past(load_en) && $past(cmp_ok) && $past(tick)));

    p_load_off_on_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !load_en);
endmodule

bind batt_test_ctrl batt_test_ctrl_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .supply_ok (supply_ok),
    .cmp_ok    (cmp_ok),
    .load_en   (load_en),
    .warn_n    (warn_n)
);

// File: tb/batt_test_ctrl_tb.sv
module batt_test_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NORM = 20;
    localparam int WARN = 5;
    localparam int PULSE = 2;
    localparam int MIN_DET = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_ok = 1'b0;
    logic recovery_done = 1'b0;
    logic cell_present = 1'b1;
    logic cmp_ok = 1'b1;
    logic load_en;
    logic warn_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    batt_test_ctrl #(
        .NORM_TICKS(NORM), .WARN_TICKS(WARN),
        .PULSE_TICKS(PULSE), .MIN_DETACH_TICKS(MIN_DET)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .recovery_done(recovery_done), .cell_present(cell_present),
        .cmp_ok(cmp_ok), .load_en(load_en), .warn_n(warn_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic count_window(output int n);
        n = 0;
        while (load_en && n < 1000) begin pulse_tick(); n++; end
    endtask

    task automatic count_gap(output int n);
        n = 0;
        while (!load_en && n < 1000) begin pulse_tick(); n++; end
    endtask

    task automatic finish_next_window();
        int g;
        int w;
        count_gap(g);
        count_window(w);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 load_en in reset", load_en, 0);
        check("R1 warn_n in reset", warn_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 load_en after reset", load_en, 0);
        check("R1 warn_n after reset", warn_n, 1);
    endtask

    task automatic t_power_up();
        int n;
        int seen;
        seen = 0;
        supply_ok = 1'b1;
        for (int i = 0; i < 4; i++) begin pulse_tick(); seen |= load_en; end
        check("R3 no test before recovery", seen, 0);
        @(negedge clk) recovery_done = 1'b1;
        @(negedge clk);
        check("R3 test starts at power-up", load_en, 1);
        cmp_ok = 1'b1;
        count_window(n);
        check("R2 window length", n, PULSE);
        check("R2 pass keeps warn released", warn_n, 1);
    endtask

    task automatic t_normal_gap();
        int n;
        count_gap(n);
        check("R4 normal gap", n, NORM);
    endtask

    task automatic t_early_low_ignored();
        cmp_ok = 1'b0;
        pulse_tick();
        cmp_ok = 1'b1;
        pulse_tick();
        check("R6 window ended", load_en, 0);
        check("R6 early low ignored", warn_n, 1);
    endtask

    task automatic t_fail_and_fast_retest();
        int n;
        count_gap(n);
        check("R4 gap before failing test", n, NORM);
        cmp_ok = 1'b0;
        count_window(n);
        check("R5 warn set on low", warn_n, 0);
        cmp_ok = 1'b1;
        count_gap(n);
        check("R7 warning gap", n, WARN);
        count_window(n);
        check("R8 pass without detach keeps warn", warn_n, 0);
    endtask

    task automatic t_short_detach();
        cell_present = 1'b0;
        repeat (MIN_DET - 1) pulse_tick();
        cell_present = 1'b1;
        @(negedge clk);
        cell_present = 1'b0;
        repeat (2) pulse_tick();
        cell_present = 1'b1;
        finish_next_window();
        check("R10 short detach does not clear", warn_n, 0);
    endtask

    task automatic t_long_detach();
        int n;
        cell_present = 1'b0;
        repeat (MIN_DET) pulse_tick();
        cell_present = 1'b1;
        finish_next_window();
        check("R9 refit then pass clears warn", warn_n, 1);
        count_gap(n);
        check("R9 normal gap resumes", n, NORM);
    endtask

    task automatic t_supply_loss();
        int seen;
        seen = 0;
        cmp_ok = 1'b0;
        @(negedge clk) begin supply_ok = 1'b0; recovery_done = 1'b0; end
        @(negedge clk);
        check("R11 load off after supply loss", load_en, 0);
        for (int i = 0; i < 6; i++) begin pulse_tick(); seen |= load_en; end
        check("R11 no test while failed", seen, 0);
        check("R11 aborted window leaves warn", warn_n, 1);
        supply_ok = 1'b1;
        @(negedge clk) recovery_done = 1'b1;
        @(negedge clk);
        check("R3 test after restore", load_en, 1);
    endtask

    task automatic t_warn_across_power();
        int n;
        int seen;
        seen = 0;
        cmp_ok = 1'b0;
        count_window(n);
        check("R5 warn set after restore test", warn_n, 0);
        cmp_ok = 1'b1;
        @(negedge clk) begin supply_ok = 1'b0; recovery_done = 1'b0; end
        for (int i = 0; i < 8; i++) begin pulse_tick(); seen |= load_en; end
        check("R11 idle while failed", seen, 0);
        check("R12 warn held through failure", warn_n, 0);
        supply_ok = 1'b1;
        @(negedge clk) recovery_done = 1'b1;
        @(negedge clk);
        check("R12 test at power-up while warned", load_en, 1);
        count_window(n);
        check("R12 window length", n, PULSE);
        check("R12 pass without detach keeps warn", warn_n, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_power_up();
        t_normal_gap();
        t_early_low_ignored();
        t_fail_and_fast_retest();
        t_short_detach();
        t_long_detach();
        t_supply_loss();
        t_warn_across_power();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule